// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single 32-bit timer channel that counts down at a fraction of the system clock and reloads itself when it passes zero. Software programs a reload value and a starting count, picks a clock divider and enables an interrupt through a small word-addressed register port. A separate start input gates counting. Each time the count would drop below zero, the counter takes the reload value and a sticky underflow flag is raised. The interrupt line follows that flag, masked by its enable bit.

The register port is synchronous. A write commits at the clock edge on which the write strobe is high. Read data is registered and appears the cycle after the read strobe. Encodings for external clocking and input capture are range-checked, but those functions are not built. Any illegal access or encoding latches an error output until reset, and the access changes no register.

Top module: `tmr_channel`

## Requirements
- R1: Word index addr[ADDR_W-1:2] selects the register: 0 is the reload value, 1 the count, 2 the control word, and 3 a general capture word that is present when HAS_CAPTURE is set and resets to 0. Read data appears on bus_rdata_o one cycle after bus_rd_i.
- R2: After reset, the reload and count values read 0xFFFFFFFF, the control word reads 0, and irq_o and err_o are 0.
- R3: Control bits [2:0] with values 0, 1, 2, 3 and 4 divide the clock by 4, 16, 64, 256 and 1024. While start_i is high, the count drops by one at the end of every divided period. A divided period consists of clock edges with start_i high.
- R4: While start_i is low, the count does not change unless software writes it.
- R5: A divided tick that finds the count at 0 loads the reload value instead of decrementing, and sets the underflow flag.
- R6: A read of the control word returns stored bits [7:0], the underflow flag in bit 8, and 0 in bit 9 and above.
- R7: A legal control write with bit 8 at 0 clears the flag. With bit 8 at 1 the flag keeps its value and is never set by the write. An underflow in the same cycle as a clear leaves the flag set.
- R8: irq_o is high exactly when the underflow flag and control bit 5 (interrupt enable) are both 1.
- R9: A count write in the same cycle as a divided tick loads the written value. An underflow in that cycle still sets the flag.
- R10: A change of control bits [2:0] restarts the divider from zero, so earlier partial periods are lost.
- R11: A control write is rejected and err_o set if any of these holds: bits [2:0] equal 5; bits [2:0] are 6 or 7 without HAS_EXTCLK; bits [4:3] are nonzero without HAS_EXTCLK; bits [7:6] equal 1; bits [7:6] are nonzero without HAS_CAPTURE; bit 9 is set without HAS_CAPTURE; or any bit at 10 or above is set. A rejected write leaves the control word and the flag unchanged.
- R12: A read or write at a word index above 3, or at index 3 without HAS_CAPTURE, sets err_o, changes no register, and returns 0 on a read. err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Count enable |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Underflow interrupt |
| err_o | output | 1 | Sticky access or encoding error |

## Verification
The countdown is exercised with a table of runs. Each run pairs a divider setting with a start count and a number of enabled clock edges that is an exact multiple of the period. Starting counts far above zero confirm the divide ratio. Starting counts of 0, 1 and 2 force one underflow, which shows that the reload value is taken instead of a wrap to all ones. A start at 0 followed by two ticks shows that counting resumes from the reload value. Directed runs then separate the three flag operations (clear, keep, and the missing set), place a count write on the exact tick edge, split a divided period around a divider change, and present each illegal encoding and address.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word indices on the register port
  localparam logic [1:0] IDX_RELOAD = 2'd0;
  localparam logic [1:0] IDX_COUNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL   = 2'd2;
  localparam logic [1:0] IDX_CAPT   = 2'd3;

  // Control word field positions
  localparam int CB_IE     = 5;
  localparam int CB_UF     = 8;
  localparam int CB_CF     = 9;
  localparam int CB_RSV_LO = 10;
  localparam int CTRL_KEEP = 8;

  localparam logic [2:0] PSC_RSVD    = 3'd5;
  localparam logic [2:0] PSC_MAX_INT = 3'd4;

  // log2 of the divide ratio for an internal selection
  function automatic logic [3:0] psc_shift(input logic [2:0] sel);
    logic [3:0] s;
    s = {1'b0, sel} + 4'd1;
    return s << 1;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import tmr_pkg::*;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       sel_q;
  logic [DIV_W:0]   term_full;
  logic             int_sel, sel_chg, at_term;

  assign int_sel   = (sel_i <= PSC_MAX_INT);
  assign sel_chg   = (sel_i != sel_q);
  assign term_full = ({{DIV_W{1'b0}}, 1'b1} << psc_shift(sel_i)) - 1'b1;
  assign at_term   = (cnt_q == term_full[DIV_W-1:0]);
  assign tick_o    = run_i & int_sel & ~sel_chg & at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (sel_chg) begin
      cnt_d = '0;
    end else if (run_i && int_sel) begin
      cnt_d = at_term ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_i;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         uflow_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign uflow_o = tick_i & at_zero;
  assign count_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      cnt_d = at_zero ? reload_i : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter bit HAS_CAPTURE = 1'b1,
  parameter bit HAS_EXTCLK  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              uflow_i,
  output logic [DATA_W-1:0] reload_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic [2:0]        psc_sel_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  import tmr_pkg::*;

  localparam int IDX_BITS = ADDR_W - 2;

  logic [IDX_BITS-1:0] idx;
  logic [1:0]          widx;
  logic                upper_zero, bad_off, ctrl_legal;
  logic                wr_reload, wr_ctrl, wr_capt, wr_ctrl_bad;

  logic [DATA_W-1:0]    reload_q, reload_d;
  logic [CTRL_KEEP-1:0] ctrl_q, ctrl_d;
  logic                 flag_q, flag_d;
  logic                 err_q, err_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic [DATA_W-1:0]    capt_val, ctrl_word;

  assign idx        = addr_i[ADDR_W-1:2];
  assign widx       = idx[1:0];
  assign upper_zero = ((idx >> 2) == '0);
  assign bad_off    = !upper_zero || (widx == IDX_CAPT && !HAS_CAPTURE);

  function automatic logic legal_ctrl(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    if (v[2:0] == PSC_RSVD)                   ok = 1'b0;
    if (v[2:0] > PSC_RSVD && !HAS_EXTCLK)     ok = 1'b0;
    if (v[4:3] != 2'b00 && !HAS_EXTCLK)       ok = 1'b0;
    if (v[7:6] == 2'b01)                      ok = 1'b0;
    if (v[7:6] != 2'b00 && !HAS_CAPTURE)      ok = 1'b0;
    if (v[CB_CF] && !HAS_CAPTURE)             ok = 1'b0;
    if (v[DATA_W-1:CB_RSV_LO] != '0)          ok = 1'b0;
    return ok;
  endfunction

  assign ctrl_legal  = legal_ctrl(wdata_i);
  assign wr_reload   = wr_i && !bad_off && widx == IDX_RELOAD;
  assign load_o      = wr_i && !bad_off && widx == IDX_COUNT;
  assign wr_ctrl     = wr_i && !bad_off && widx == IDX_CTRL && ctrl_legal;
  assign wr_ctrl_bad = wr_i && !bad_off && widx == IDX_CTRL && !ctrl_legal;
  assign wr_capt     = wr_i && !bad_off && widx == IDX_CAPT;
  assign load_val_o  = wdata_i;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_KEEP-1:0] = ctrl_q;
    ctrl_word[CB_UF] = flag_q;
  end

  generate
    if (HAS_CAPTURE) begin : g_capt
      logic [DATA_W-1:0] capt_q, capt_d;
      always_comb begin
        capt_d = capt_q;
        if (wr_capt) capt_d = wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) capt_q <= '0;
        else        capt_q <= capt_d;
      end
      assign capt_val = capt_q;
    end else begin : g_no_capt
      assign capt_val = '0;
    end
  endgenerate

  always_comb begin
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    flag_d   = flag_q;
    err_d    = err_q;
    rdata_d  = rdata_q;
    if (wr_reload) reload_d = wdata_i;
    if (wr_ctrl) begin
      ctrl_d = wdata_i[CTRL_KEEP-1:0];
      if (!wdata_i[CB_UF]) flag_d = 1'b0;
    end
    if (uflow_i) flag_d = 1'b1;
    if (((wr_i || rd_i) && bad_off) || wr_ctrl_bad) err_d = 1'b1;
    if (rd_i) begin
      if (bad_off) begin
        rdata_d = '0;
      end else begin
        unique case (widx)
          IDX_RELOAD: rdata_d = reload_q;
          IDX_COUNT:  rdata_d = count_i;
          IDX_CTRL:   rdata_d = ctrl_word;
          default:    rdata_d = capt_val;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
      err_q    <= err_d;
      rdata_q  <= rdata_d;
    end
  end

  assign reload_o  = reload_q;
  assign psc_sel_o = ctrl_q[2:0];
  assign ie_o      = ctrl_q[CB_IE];
  assign flag_o    = flag_q;
  assign err_o     = err_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int DIV_W       = 10,
  parameter bit HAS_CAPTURE = 1'b1,
  parameter bit HAS_EXTCLK  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              err_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              tick, uflow, cnt_load, ie, uf_flag;
  logic [2:0]        psc_sel;
  logic [DATA_W-1:0] count_val, reload_val, cnt_load_val;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  tmr_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (start_i),
    .sel_i  (psc_sel),
    .tick_o (tick)
  );

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .reload_i   (reload_val),
    .count_o    (count_val),
    .uflow_o    (uflow)
  );

  tmr_regs #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .HAS_CAPTURE (HAS_CAPTURE),
    .HAS_EXTCLK  (HAS_EXTCLK)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .count_i    (count_val),
    .uflow_i    (uflow),
    .reload_o   (reload_val),
    .load_o     (cnt_load),
    .load_val_o (cnt_load_val),
    .psc_sel_o  (psc_sel),
    .ie_o       (ie),
    .flag_o     (uf_flag),
    .err_o      (err_o),
    .rdata_o    (bus_rdata_o)
  );

  assign irq_o = uf_flag & ie;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              err_o,
  input logic              tick,
  input logic              uflow,
  input logic              load,
  input logic [DATA_W-1:0] load_val,
  input logic [DATA_W-1:0] reload,
  input logic [DATA_W-1:0] count,
  input logic              flag
);

  p_tick_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> start_i);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !load) |=> $stable(count));

  p_reload_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !load) |=> (count == $past(reload)));

  p_flag_only_by_uflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(uflow));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .err_o    (err_o),
  .tick     (tick),
  .uflow    (uflow),
  .load     (cnt_load),
  .load_val (cnt_load_val),
  .reload   (reload_val),
  .count    (count_val),
  .flag     (uf_flag)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_RELOAD = 6'h00;
  localparam logic [AW-1:0] A_COUNT  = 6'h04;
  localparam logic [AW-1:0] A_CTRL   = 6'h08;
  localparam logic [AW-1:0] A_CAPT   = 6'h0C;
  localparam logic [AW-1:0] A_BAD    = 6'h10;
  localparam int NV = 7;

  // divider select, start count, enabled edges, expected count, expected flag
  localparam int unsigned V_PSC  [NV] = '{0, 0, 0, 1, 2, 3, 4};
  localparam int unsigned V_K    [NV] = '{10, 1, 0, 5, 2, 0, 7};
  localparam int unsigned V_E    [NV] = '{8, 8, 4, 32, 192, 512, 2048};
  localparam int unsigned V_EXP  [NV] = '{8, 100, 100, 3, 100, 99, 5};
  localparam int unsigned V_FLAG [NV] = '{0, 1, 1, 0, 1, 1, 0};

  logic          clk, rst_n, start, wr, rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          irq, err;
  int            checks, errors;
  logic [DW-1:0] v;

  tmr_channel u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .err_o       (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    start = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic run_edges(input int n);
    @(negedge clk);
    start = 1'b1;
    repeat (n) @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    do_reset();

    // R2: reset state
    bus_read(A_RELOAD, v); chk("R2 reload", v, 32'hFFFF_FFFF);
    bus_read(A_COUNT, v);  chk("R2 count", v, 32'hFFFF_FFFF);
    bus_read(A_CTRL, v);   chk("R2 ctrl", v, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'h0);
    chk("R2 err", {31'b0, err}, 32'h0);

    // R1: reload readback
    bus_write(A_RELOAD, 32'd100);
    bus_read(A_RELOAD, v); chk("R1 reload", v, 32'd100);

    // R3 R5 R8: vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(A_CTRL, V_PSC[i] | 32'h20);
      bus_write(A_COUNT, V_K[i]);
      run_edges(V_E[i]);
      bus_read(A_COUNT, v);
      chk("R3/R5 count", v, V_EXP[i]);
      bus_read(A_CTRL, v);
      chk("R5/R6 ctrl", v, V_PSC[i] | 32'h20 | (V_FLAG[i] << 8));
      chk("R8 irq", {31'b0, irq}, V_FLAG[i]);
    end

    // R4: no counting while start is low
    bus_write(A_COUNT, 32'd20);
    repeat (50) @(negedge clk);
    bus_read(A_COUNT, v); chk("R4 hold", v, 32'd20);

    // R7 R8: flag handling
    bus_write(A_CTRL, 32'h20);
    bus_write(A_COUNT, 32'd0);
    run_edges(4);
    chk("R8 irq set", {31'b0, irq}, 32'h1);
    bus_write(A_CTRL, 32'h120);
    bus_read(A_CTRL, v); chk("R7 keep", v, 32'h120);
    bus_write(A_CTRL, 32'h100);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL, v); chk("R8 flag kept", v, 32'h100);
    bus_write(A_CTRL, 32'h20);
    bus_read(A_CTRL, v); chk("R7 clear", v, 32'h20);
    bus_write(A_CTRL, 32'h120);
    bus_read(A_CTRL, v); chk("R7 no set", v, 32'h20);
    chk("R7 irq low", {31'b0, irq}, 32'h0);

    // R10: divider restarts on selection change
    bus_write(A_COUNT, 32'd50);
    run_edges(2);
    bus_write(A_CTRL, 32'h21);
    bus_write(A_CTRL, 32'h20);
    run_edges(3);
    bus_read(A_COUNT, v); chk("R10 restart", v, 32'd50);

    // R9: count write on the tick edge
    bus_write(A_CTRL, 32'h21);
    bus_write(A_CTRL, 32'h20);
    bus_write(A_COUNT, 32'd0);
    @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    wr = 1'b1; addr = A_COUNT; wdata = 32'd55;
    @(negedge clk);
    wr = 1'b0; start = 1'b0;
    bus_read(A_COUNT, v); chk("R9 load wins", v, 32'd55);
    bus_read(A_CTRL, v);  chk("R9 flag set", v, 32'h120);

    // R11: reserved divider value rejected, flag untouched
    chk("R11 err before", {31'b0, err}, 32'h0);
    bus_write(A_CTRL, 32'h05);
    chk("R11 err psc5", {31'b0, err}, 32'h1);
    bus_read(A_CTRL, v); chk("R11 unchanged", v, 32'h120);

    // R1 R12: capture word and bad offset
    do_reset();
    bus_write(A_CAPT, 32'hA5A5_0F0F);
    bus_read(A_CAPT, v); chk("R1 capture", v, 32'hA5A5_0F0F);
    chk("R1 no err", {31'b0, err}, 32'h0);
    bus_read(A_BAD, v); chk("R12 rdata", v, 32'h0);
    chk("R12 err", {31'b0, err}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R12 sticky", {31'b0, err}, 32'h1);

    // R11: edge field, capture field, high bits
    do_reset();
    bus_write(A_CTRL, 32'h200);
    chk("R11 bit9 legal", {31'b0, err}, 32'h0);
    bus_read(A_CTRL, v); chk("R6 bit9 zero", v, 32'h0);
    bus_write(A_CTRL, 32'h08);
    chk("R11 edge", {31'b0, err}, 32'h1);
    do_reset();
    bus_write(A_CTRL, 32'h40);
    chk("R11 icp01", {31'b0, err}, 32'h1);
    do_reset();
    bus_write(A_CTRL, 32'h0001_0000);
    chk("R11 high bits", {31'b0, err}, 32'h1);
    bus_read(A_CTRL, v); chk("R11 ctrl kept", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule